// File: doc/BRIEF.md
# Synchronized Dual-Channel PWM Timer

This block holds two 16-bit up-counters that advance on a shared divided-down count tick. Each channel has a period compare value and a duty compare value, and from them it produces a PWM waveform on its own output pin. With both channels on the same tick and different duty values, the two pins form a two-phase PWM pair.

A coupling bit ties the counters together. While it is set, loading a start value into either counter loads both counters in the same clock. A period-match clear on either counter also clears both. A channel whose own period clear is switched off can therefore take its restart from the other channel.

The pins can be handed back to plain port levels in two ways. One is a per-pin disable mask written over the configuration bus. The other is an asynchronous trip input. After two synchronizing flops, the trip forces the whole mask to "disabled". Configuration arrives over a simple single-cycle write port with no back-pressure: a write is accepted in every cycle in which `wr_en` is high.

Top module: `pwm2_sync_timer`

## Requirements
- R1: With the coupling bit clear, a load written to one channel's counter leaves the other channel's counter unchanged, and each channel clears only on its own period match.
- R2: With the run bit set, both counters advance by one once every DIV+1 clocks, where DIV is the divider register. Writing the divider restarts the divide phase. With the run bit clear, both counters hold their values.
- R3: With the coupling bit set, a load written to either counter's address loads both counters with the written value in the same clock.
- R4: With the coupling bit set, a period-match clear on either channel clears both counters in the same clock. A channel with its own clear switched off restarts together with the other channel.
- R5: A channel whose period clear is enabled counts 0 to PERIOD and then returns to 0 on the next tick, giving PERIOD+1 counts per cycle. With the clear disabled, the counter wraps from 16'hFFFF to 0.
- R6: An enabled pin is 1 while count < DUTY and 0 from count == DUTY up to the end of the period. When DUTY >= PERIOD the pin stays at 1, and when DUTY is 0 (with a nonzero PERIOD) it stays at 0.
- R7: Disable mask bit i set to 1 makes pin i follow port_val[i]. The mask resets to all ones. A mask write changes the pins right after the clock edge that accepts it.
- R8: A high level on ext_trip, after two flops on clk, makes both pins follow port_val. One clock later it sets the whole mask to ones, and the mask stays set after the trip falls until it is rewritten. Mask writes are ignored while the synchronized trip is high.
- R9: Register map (wr_addr, value in wr_data): 0 control {bit3 channel-1 period clear enable, bit2 channel-0 period clear enable, bit1 coupling, bit0 run}; 1 divider; 2 and 3 counter load for channels 0 and 1; 4 and 5 channel-0 period and duty; 6 and 7 channel-1 period and duty; 8 disable mask {bit1 pin 1, bit0 pin 0}. All registers except the mask reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per high cycle |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write value |
| ext_trip | input | 1 | Asynchronous output-disable trip |
| port_val | input | 2 | Levels the pins take when disabled |
| pwm_pin | output | 2 | PWM output pins |

## Verification
The assertions assume the divider register is only changed through its own address, because that write also restarts the divide phase. Under that assumption the divide phase never exceeds the divider value. They also assume ext_trip is a level held for at least a clock, so that the two-flop delay can be observed. The bench changes every input on the falling clock edge and drives the trip as a level lasting whole cycles. It changes the divider only through register writes, so these assumptions always hold.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;
  localparam int NUM_CH = 2;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 4'd0,
    REG_DIV  = 4'd1,
    REG_LD0  = 4'd2,
    REG_LD1  = 4'd3,
    REG_PER0 = 4'd4,
    REG_DTY0 = 4'd5,
    REG_PER1 = 4'd6,
    REG_DTY1 = 4'd7,
    REG_MASK = 4'd8
  } reg_addr_e;

  typedef struct packed {
    logic clr1_en;
    logic clr0_en;
    logic couple;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/pwm2_prescaler.sv
module pwm2_prescaler #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PSC_W-1:0] div,
  output logic             tick
);
  logic [PSC_W-1:0] phase_q;

  assign tick = run && (phase_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               phase_q <= '0;
    else if (restart || tick) phase_q <= '0;
    else if (run)             phase_q <= phase_q + 1'b1;
  end

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (phase_q <= div)); // R2
endmodule

// File: rtl/pwm2_channel.sv
module pwm2_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clr_en,
  input  logic             clr_peer,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty,
  output logic             own_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             wave
);
  logic [CNT_W-1:0] cnt_q;

  assign own_clr = clr_en && tick && (cnt_q == period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (load)                cnt_q <= load_val;
    else if (own_clr || clr_peer) cnt_q <= '0;
    else if (tick)                cnt_q <= cnt_q + 1'b1;
  end

  assign cnt  = cnt_q;
  assign wave = (cnt_q < duty) || (duty >= period);

  AST_CLEAR_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (own_clr && !load) |=> (cnt_q == '0)); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load && !clr_peer) |=> $stable(cnt_q)); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !own_clr && !clr_peer) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R2
endmodule

// File: rtl/pwm2_outgate.sv
module pwm2_outgate #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           trip_async,
  input  logic           mask_wr,
  input  logic [NCH-1:0] mask_val,
  input  logic [NCH-1:0] wave,
  input  logic [NCH-1:0] port_val,
  output logic [NCH-1:0] pins
);
  logic           sync1_q, sync2_q;
  logic [NCH-1:0] mask_q;
  logic [NCH-1:0] off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= trip_async;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (sync2_q) mask_q <= '1;
    else if (mask_wr) mask_q <= mask_val;
  end

  assign off = mask_q | {NCH{sync2_q}};

  for (genvar i = 0; i < NCH; i++) begin : g_pin
    assign pins[i] = off[i] ? port_val[i] : wave[i];
  end

  AST_TRIP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    sync2_q |=> (mask_q == '1)); // R8
  AST_TRIP_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync2_q) |-> $past(sync1_q)); // R8
  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && !sync2_q) |=> (mask_q == $past(mask_val))); // R7
endmodule

// File: rtl/pwm2_sync_timer.sv
module pwm2_sync_timer
  import pwm2_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              ext_trip,
  input  logic [NUM_CH-1:0] port_val,
  output logic [NUM_CH-1:0] pwm_pin
);
  localparam logic [ADDR_W-1:0] LD_BASE  = ADDR_W'(REG_LD0);
  localparam logic [ADDR_W-1:0] PER_BASE = ADDR_W'(REG_PER0);

  ctrl_t            ctrl_q;
  logic [PSC_W-1:0] div_q;
  logic             tick;
  logic             any_load;
  logic [NUM_CH-1:0] own_clr, load, wave;
  logic [CNT_W-1:0] cnt    [NUM_CH];
  logic [CNT_W-1:0] per_q  [NUM_CH];
  logic [CNT_W-1:0] duty_q [NUM_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == REG_CTRL) ctrl_q <= ctrl_t'(wr_data[3:0]);
      if (wr_addr == REG_DIV)  div_q  <= wr_data[PSC_W-1:0];
    end
  end

  pwm2_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q.run),
    .restart (wr_en && (wr_addr == REG_DIV)),
    .div     (div_q),
    .tick    (tick)
  );

  assign any_load = wr_en && ((wr_addr == REG_LD0) || (wr_addr == REG_LD1));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] LD_A  = LD_BASE + ADDR_W'(i);
    localparam logic [ADDR_W-1:0] PER_A = PER_BASE + ADDR_W'(2 * i);
    localparam logic [ADDR_W-1:0] DTY_A = PER_BASE + ADDR_W'(2 * i + 1);
    localparam logic [NUM_CH-1:0] SELF  = NUM_CH'(1) << i;
    logic clr_en, clr_peer;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        per_q[i]  <= '0;
        duty_q[i] <= '0;
      end else if (wr_en) begin
        if (wr_addr == PER_A) per_q[i]  <= wr_data;
        if (wr_addr == DTY_A) duty_q[i] <= wr_data;
      end
    end

    assign load[i]  = (wr_en && (wr_addr == LD_A)) || (ctrl_q.couple && any_load);
    assign clr_en   = (i == 0) ? ctrl_q.clr0_en : ctrl_q.clr1_en;
    assign clr_peer = ctrl_q.couple && |(own_clr & ~SELF);

    pwm2_channel #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .load     (load[i]),
      .load_val (wr_data),
      .clr_en   (clr_en),
      .clr_peer (clr_peer),
      .period   (per_q[i]),
      .duty     (duty_q[i]),
      .own_clr  (own_clr[i]),
      .cnt      (cnt[i]),
      .wave     (wave[i])
    );
  end

  pwm2_outgate #(.NCH(NUM_CH)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .trip_async (ext_trip),
    .mask_wr    (wr_en && (wr_addr == REG_MASK)),
    .mask_val   (wr_data[NUM_CH-1:0]),
    .wave       (wave),
    .port_val   (port_val),
    .pins       (pwm_pin)
  );

  AST_COUPLED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.couple && any_load) |=> (cnt[0] == cnt[1])); // R3
  AST_COUPLED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.couple && (own_clr != '0) && !any_load) |=> ((cnt[0] == '0) && (cnt[1] == '0))); // R4
  AST_SPLIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.couple && wr_en && (wr_addr == REG_LD0) && !tick) |=> $stable(cnt[1])); // R1
endmodule

// File: tb/pwm2_sync_timer_tb_top.sv
`timescale 1ns/1ps
module pwm2_sync_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        ext_trip = 1'b0;
  logic [1:0]  port_val = 2'b10;
  logic [1:0]  pwm_pin;

  int total = 0;
  int bad = 0;
  bit chk_on = 0;
  string tag = "R7";

  // reference state, computed from the requirements
  int  m_c[2], m_p[2], m_d[2];
  int  m_div, m_psc;
  bit  m_run, m_cpl, m_ce0, m_ce1, m_s1, m_s2;
  bit  [1:0] m_mask;
  bit  tk, o0, o1, l0, l1;
  int  n0, n1;

  always #2.5 clk = ~clk;

  pwm2_sync_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ext_trip(ext_trip), .port_val(port_val), .pwm_pin(pwm_pin)
  );

  function automatic bit [1:0] exp_pins();
    bit [1:0] r;
    for (int i = 0; i < 2; i++) begin
      bit w;
      w = (m_c[i] < m_d[i]) || (m_d[i] >= m_p[i]);
      r[i] = (m_mask[i] || m_s2) ? port_val[i] : w;
    end
    return r;
  endfunction

  task automatic check(string t, bit [1:0] act, bit [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: pins actual=%b expected=%b at %0t", t, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_c = '{0, 0}; m_p = '{0, 0}; m_d = '{0, 0};
      m_div = 0; m_psc = 0; m_run = 0; m_cpl = 0; m_ce0 = 0; m_ce1 = 0;
      m_s1 = 0; m_s2 = 0; m_mask = 2'b11;
    end else begin
      tk = m_run && (m_psc == m_div);
      o0 = m_ce0 && tk && (m_c[0] == m_p[0]);
      o1 = m_ce1 && tk && (m_c[1] == m_p[1]);
      l0 = wr_en && (wr_addr == 2 || (m_cpl && wr_addr == 3));
      l1 = wr_en && (wr_addr == 3 || (m_cpl && wr_addr == 2));
      n0 = l0 ? int'(wr_data) : (o0 || (m_cpl && o1)) ? 0 : tk ? (m_c[0] + 1) % 65536 : m_c[0];
      n1 = l1 ? int'(wr_data) : (o1 || (m_cpl && o0)) ? 0 : tk ? (m_c[1] + 1) % 65536 : m_c[1];
      m_c[0] = n0; m_c[1] = n1;
      if (wr_en && wr_addr == 1) m_psc = 0;
      else if (tk) m_psc = 0;
      else if (m_run) m_psc = m_psc + 1;
      if (m_s2) m_mask = 2'b11;
      else if (wr_en && wr_addr == 8) m_mask = wr_data[1:0];
      m_s2 = m_s1; m_s1 = ext_trip;
      if (wr_en) begin
        case (wr_addr)
          4'd0: begin m_run = wr_data[0]; m_cpl = wr_data[1]; m_ce0 = wr_data[2]; m_ce1 = wr_data[3]; end
          4'd1: m_div = int'(wr_data[7:0]);
          4'd4: m_p[0] = int'(wr_data);
          4'd5: m_d[0] = int'(wr_data);
          4'd6: m_p[1] = int'(wr_data);
          4'd7: m_d[1] = int'(wr_data);
          default: ;
        endcase
      end
    end
    #1;
    if (chk_on) check(tag, pwm_pin, exp_pins());
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(1);
    check("R7 reset mask", pwm_pin, 2'b10);
    chk_on = 1;

    tag = "R7 enable";
    wr(8, 0);
    idle(3);

    // R2 R5 R6 R9: uncoupled sweep over divider, period and duty
    tag = "R2 R5 R6 R9 sweep";
    for (int dv = 0; dv < 3; dv++)
      for (int p = 0; p < 5; p++)
        for (int d = 0; d < 6; d++) begin
          wr(0, 0); wr(1, dv);
          wr(4, p); wr(5, d); wr(6, p + 2); wr(7, 5 - d);
          wr(2, 0); wr(3, 0);
          wr(0, 4'b1101);
          idle((p + 4) * (dv + 1) * 2);
        end

    // R4: coupled, channel 1 follows channel 0
    tag = "R4 follow";
    for (int p = 0; p < 6; p++) begin
      wr(0, 0); wr(1, 1);
      wr(4, p); wr(5, p / 2); wr(6, 7); wr(7, 3);
      wr(3, 9);
      wr(0, 4'b0111);
      idle(40);
    end
    // R4: channel 1's own match clears channel 0 too
    tag = "R4 reverse";
    wr(0, 0); wr(1, 0);
    wr(4, 20); wr(5, 4); wr(6, 2); wr(7, 1);
    wr(0, 4'b1011);
    idle(30);

    // R3: coupled loads
    tag = "R3 coupled load";
    wr(0, 0); wr(4, 16'hFFFF); wr(6, 16'hFFFF); wr(5, 102); wr(7, 101);
    wr(0, 4'b0011);
    wr(3, 100);
    idle(6);
    wr(2, 98);
    idle(6);

    // R1: uncoupled load stays local
    tag = "R1 split load";
    wr(0, 4'b0001); wr(1, 3);
    wr(5, 12); wr(7, 12);
    wr(2, 10);
    idle(20);
    wr(3, 9);
    idle(20);

    // R5: wrap without clear
    tag = "R5 wrap";
    wr(1, 0); wr(5, 2); wr(7, 3);
    wr(2, 16'hFFFC); wr(3, 16'hFFFD);
    idle(12);

    // R2: run off holds
    tag = "R2 hold";
    wr(2, 1); wr(3, 3);
    wr(0, 0);
    idle(20);
    wr(0, 4'b1101); wr(4, 4); wr(6, 4); wr(5, 2); wr(7, 2);
    idle(20);

    // R8: trip
    tag = "R8 trip";
    port_val = 2'b01;
    @(negedge clk); ext_trip = 1'b1;
    @(negedge clk); ext_trip = 1'b0;
    idle(8);
    check("R8 latched", pwm_pin, 2'b01);
    wr(8, 0);
    idle(10);

    // R7: single-pin disable
    tag = "R7 mask";
    wr(8, 2);
    port_val = 2'b00; idle(5);
    port_val = 2'b11; idle(5);
    wr(8, 1);
    port_val = 2'b10; idle(5);
    wr(8, 3);
    idle(3);
    check("R7 all masked", pwm_pin, 2'b10);

    chk_on = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule